// File: doc/BRIEF.md
# Dual-Channel Serial DAC Input Register

This block is the digital front end of a two-channel 12-bit digital-to-analog converter. A host writes a code over a three-wire serial link (an active-low select, a serial clock and a data line) into a single shift register. Two holding registers, one per channel, then take that code when their own active-low load strobe is low. The holding registers drive the converter codes.

A shared active-low preset input forces both holding registers to a known value. A mode input picks the value: half-scale (800H) or zero. A shutdown input is passed through as a status flag and never alters stored data. Every external pin is sampled in one fast system-clock domain through a synchronizer, and pin edges are found by comparing successive samples. A one-cycle error pulse marks a serial shift taken while a load strobe is low.

Top module: `dual_dac_front`

## Requirements
- R1: After system reset (`rst_n` low), `code_a` and `code_b` are 000H, and `sleep_flag` and `proto_err` are 0.
- R2: While `sel_n` is low, each rising edge of `sclk` shifts `sdata` into the 12-bit shift register, most significant bit first. After 12 edges the register holds the word that was sent.
- R3: While `sel_n` is high, `sclk` edges do not change the shift register.
- R4: While a load strobe (`load_a_n` or `load_b_n`) is low, its holding register follows the shift register.
- R5: After its strobe returns high, a holding register keeps the value it had at that moment, even when later words are shifted in.
- R6: The load strobes act whatever the level of `sel_n`.
- R7: A strobe for one channel leaves the other channel's holding register unchanged.
- R8: While `preset_n` is low, both holding registers are forced to 800H if `preset_mid` is 1, or to 000H if it is 0. They keep that value after `preset_n` returns high.
- R9: When `preset_n` and a load strobe are low in the same cycle, the preset wins.
- R10: `sleep_flag` is 1 while `sleep_n` is low. `sleep_n` does not change the shift register or either holding register.
- R11: `proto_err` pulses high for one system-clock cycle for each shift taken while either load strobe is low, and stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all pins |
| rst_n | input | 1 | Asynchronous active-low system reset |
| sel_n | input | 1 | Active-low serial select |
| sclk | input | 1 | Serial clock; a rising edge shifts one bit |
| sdata | input | 1 | Serial data, MSB first |
| load_a_n | input | 1 | Active-low load strobe, channel A |
| load_b_n | input | 1 | Active-low load strobe, channel B |
| preset_n | input | 1 | Active-low preset of both holding registers |
| preset_mid | input | 1 | Preset value select: 1 gives 800H, 0 gives 000H |
| sleep_n | input | 1 | Active-low shutdown request |
| code_a | output | CODE_W | Channel A converter code |
| code_b | output | CODE_W | Channel B converter code |
| sleep_flag | output | 1 | High while shutdown is requested |
| proto_err | output | 1 | One-cycle pulse when a shift occurs while a strobe is low |

## Verification
The main path is driven with a sweep of codes spread over the whole 12-bit range, plus all-ones and all-zeros. The channels alternate, so a swapped bit order, a dropped bit or a crossed channel shows up as a wrong value on one side. A burst clocked with select high, followed by a load, shows whether idle clocks leak into the shift register. A word shifted after a strobe is released tells a latched holding register apart from one that stays transparent. Preset is tried in both modes and overlapped with a strobe to expose the wrong priority. A deliberate shift under a low strobe shows the error pulse count and the transparent follow.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  // Sampled external pins, in one vector for the synchronizer.
  typedef struct packed {
    logic sel_n;
    logic sclk;
    logic sdata;
    logic load_a_n;
    logic load_b_n;
    logic preset_n;
    logic preset_mid;
    logic sleep_n;
  } pins_t;

  localparam int unsigned PIN_N = $bits(pins_t);

  // Inactive level of every pin, loaded while the system reset is held.
  localparam pins_t PIN_IDLE = '{
    sel_n:      1'b1,
    sclk:       1'b0,
    sdata:      1'b0,
    load_a_n:   1'b1,
    load_b_n:   1'b1,
    preset_n:   1'b1,
    preset_mid: 1'b0,
    sleep_n:    1'b1
  };

  localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d;
    end else begin : g_next
      assign stg_d = stg[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else        stg[s] <= stg_d;
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/serial_shifter.sv
module serial_shifter #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] sr
);

  logic [W-1:0] sr_d;

  always_comb begin
    sr_d = sr;
    if (shift_en) sr_d = {sr[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= sr_d;
  end

  // R2: a shift moves the word up one place and appends the new bit
  a_r2_shift_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sr == {$past(sr[W-2:0]), $past(din)});

  // R3: no shift enable, no change
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr));

endmodule

// File: rtl/hold_reg.sv
module hold_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         preset,
  input  logic         preset_mid,
  input  logic         load,
  input  logic [W-1:0] shreg_i,
  output logic [W-1:0] code
);

  localparam logic [W-1:0] MID_CODE  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ZERO_CODE = '0;

  logic [W-1:0] code_d;

  // Preset first, then the transparent load, else hold.
  always_comb begin
    code_d = code;
    if (preset)    code_d = preset_mid ? MID_CODE : ZERO_CODE;
    else if (load) code_d = shreg_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code <= '0;
    else        code <= code_d;
  end

  // R8 and R9: a preset forces the selected value, whatever the strobe does
  a_r8_preset_value: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> code == ($past(preset_mid) ? MID_CODE : ZERO_CODE));

  // R4: a low strobe makes the register follow the shift register
  a_r4_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !preset) |=> code == $past(shreg_i));

  // R5: with neither preset nor strobe the stored code stays put
  a_r5_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !preset) |=> $stable(code));

endmodule

// File: rtl/dual_dac_front.sv
module dual_dac_front #(
  parameter int unsigned CODE_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              load_a_n,
  input  logic              load_b_n,
  input  logic              preset_n,
  input  logic              preset_mid,
  input  logic              sleep_n,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              sleep_flag,
  output logic              proto_err
);

  import dacfe_pkg::*;

  pins_t raw, syn, prv;

  always_comb begin
    raw.sel_n      = sel_n;
    raw.sclk       = sclk;
    raw.sdata      = sdata;
    raw.load_a_n   = load_a_n;
    raw.load_b_n   = load_b_n;
    raw.preset_n   = preset_n;
    raw.preset_mid = preset_mid;
    raw.sleep_n    = sleep_n;
  end

  pin_sync #(
    .W       (PIN_N),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (syn)
  );

  // Previous sample of every pin, used for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prv <= PIN_IDLE;
    else        prv <= syn;
  end

  logic              sclk_rise;
  logic              shift_en;
  logic [NUM_CH-1:0] load_act;
  logic [CODE_W-1:0] shreg;
  logic [CODE_W-1:0] code [NUM_CH];
  logic              err_d;

  assign sclk_rise   = syn.sclk & ~prv.sclk;
  assign shift_en    = sclk_rise & ~syn.sel_n;
  assign load_act[0] = ~syn.load_a_n;
  assign load_act[1] = ~syn.load_b_n;

  serial_shifter #(.W(CODE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .din      (syn.sdata),
    .sr       (shreg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    hold_reg #(.W(CODE_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .preset     (~syn.preset_n),
      .preset_mid (syn.preset_mid),
      .load       (load_act[c]),
      .shreg_i    (shreg),
      .code       (code[c])
    );
  end

  assign code_a = code[0];
  assign code_b = code[1];

  // Error pulse: a shift taken while any strobe is low.
  assign err_d = shift_en & (|load_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) proto_err <= 1'b0;
    else        proto_err <= err_d;
  end

  assign sleep_flag = ~syn.sleep_n;

  // R11: the flag marks exactly the cycles after a shift under a low strobe
  a_r11_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err == $past(shift_en && (load_act != '0)));

  // R11: the flag never lasts longer than the one-cycle shift edge
  a_r11_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> !proto_err);

endmodule

// File: tb/tb_dual_dac_front.sv
module tb_dual_dac_front;

  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic sel_n, sclk, sdata, load_a_n, load_b_n, preset_n, preset_mid, sleep_n;
  logic [W-1:0] code_a, code_b;
  logic sleep_flag, proto_err;

  int n_chk  = 0;
  int n_fail = 0;
  int err_seen = 0;
  bit done = 0;

  logic [W-1:0] exp_sr, exp_a, exp_b;

  always #5 clk = ~clk;

  dual_dac_front dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdata(sdata),
    .load_a_n(load_a_n), .load_b_n(load_b_n), .preset_n(preset_n),
    .preset_mid(preset_mid), .sleep_n(sleep_n), .code_a(code_a),
    .code_b(code_b), .sleep_flag(sleep_flag), .proto_err(proto_err)
  );

  always @(posedge clk) if (rst_n && proto_err) err_seen++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends 12 bits MSB first; the shift register only moves when select is low.
  task automatic send_word(input logic [W-1:0] w, input bit use_sel);
    sel_n = use_sel ? 1'b0 : 1'b1;
    wait_cyc(4);
    for (int i = W - 1; i >= 0; i--) begin
      sdata = w[i];
      wait_cyc(3);
      sclk = 1'b1;
      wait_cyc(4);
      sclk = 1'b0;
      wait_cyc(3);
    end
    sel_n = 1'b1;
    wait_cyc(6);
    if (use_sel) exp_sr = w;
  endtask

  task automatic strobe(input int ch, input string req);
    if (ch == 0) load_a_n = 1'b0; else load_b_n = 1'b0;
    wait_cyc(6);
    if (ch == 0) exp_a = exp_sr; else exp_b = exp_sr;
    chk({req, " follow while low"}, ch == 0 ? code_a : code_b, exp_sr);
    if (ch == 0) load_a_n = 1'b1; else load_b_n = 1'b1;
    wait_cyc(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    sel_n = 1'b1; sclk = 1'b0; sdata = 1'b0;
    load_a_n = 1'b1; load_b_n = 1'b1;
    preset_n = 1'b1; preset_mid = 1'b0; sleep_n = 1'b1;
    exp_sr = '0; exp_a = '0; exp_b = '0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);

    // R1: reset state
    chk("R1 code_a", code_a, 0);
    chk("R1 code_b", code_b, 0);
    chk("R1 sleep_flag", sleep_flag, 0);
    chk("R1 proto_err", proto_err, 0);

    // R2, R4, R6, R7: sweep of codes, channels alternating, strobes with select high
    for (int v = 0; v < 4096 + 37; v += 37) begin
      automatic logic [W-1:0] word = (v >= 4096) ? 12'hFFF : v[W-1:0];
      automatic int ch = (v / 37) % 2;
      send_word(word, 1'b1);
      strobe(ch, "R4 R6");
      chk("R2 target code", ch == 0 ? code_a : code_b, word);
      chk("R7 other channel", ch == 0 ? code_b : code_a, ch == 0 ? exp_b : exp_a);
    end

    // R3: bits clocked with select high are ignored
    send_word(12'h5A5, 1'b0);
    strobe(0, "R3");
    chk("R3 shift register unchanged", code_a, exp_sr);

    // R5: a released strobe latches; later words do not leak through
    send_word(12'h3C7, 1'b1);
    strobe(1, "R5");
    send_word(12'h0E1, 1'b1);
    chk("R5 code_b latched", code_b, 12'h3C7);
    chk("R5 code_a latched", code_a, exp_a);

    // R6: strobe while select is low
    sel_n = 1'b0;
    wait_cyc(4);
    load_a_n = 1'b0;
    wait_cyc(6);
    load_a_n = 1'b1;
    wait_cyc(6);
    sel_n = 1'b1;
    exp_a = exp_sr;
    chk("R6 load with select low", code_a, 12'h0E1);

    // R8: half-scale preset, held after release
    preset_mid = 1'b1;
    preset_n = 1'b0;
    wait_cyc(6);
    chk("R8 mid code_a", code_a, 12'h800);
    chk("R8 mid code_b", code_b, 12'h800);
    preset_n = 1'b1;
    wait_cyc(6);
    chk("R8 mid held a", code_a, 12'h800);
    chk("R8 mid held b", code_b, 12'h800);

    // R8: zero preset
    preset_mid = 1'b0;
    preset_n = 1'b0;
    wait_cyc(6);
    preset_n = 1'b1;
    wait_cyc(6);
    chk("R8 zero code_a", code_a, 0);
    chk("R8 zero code_b", code_b, 0);

    // R9: preset overrides a low strobe
    preset_mid = 1'b1;
    load_a_n = 1'b0;
    load_b_n = 1'b0;
    preset_n = 1'b0;
    wait_cyc(6);
    chk("R9 preset wins a", code_a, 12'h800);
    chk("R9 preset wins b", code_b, 12'h800);
    preset_n = 1'b1;
    wait_cyc(6);
    chk("R9 follow resumes a", code_a, exp_sr);
    load_a_n = 1'b1;
    load_b_n = 1'b1;
    preset_mid = 1'b0;
    wait_cyc(6);
    exp_a = exp_sr; exp_b = exp_sr;

    // R10: shutdown is reported and touches no register
    sleep_n = 1'b0;
    wait_cyc(6);
    chk("R10 sleep_flag set", sleep_flag, 1);
    chk("R10 code_a kept", code_a, exp_a);
    chk("R10 code_b kept", code_b, exp_b);
    sleep_n = 1'b1;
    wait_cyc(6);
    chk("R10 sleep_flag clear", sleep_flag, 0);
    send_word(12'h000, 1'b0);
    strobe(1, "R10");
    chk("R10 shift register kept", code_b, 12'h0E1);

    // R11: no pulses during legal traffic, one per shift under a low strobe
    chk("R11 no error on legal traffic", err_seen, 0);
    load_b_n = 1'b0;
    wait_cyc(6);
    send_word(12'h9B4, 1'b1);
    chk("R11 transparent during shift", code_b, 12'h9B4);
    load_b_n = 1'b1;
    wait_cyc(6);
    chk("R11 error pulse count", err_seen, 12);
    chk("R11 code_a untouched", code_a, exp_a);

    finish_run();
  end

endmodule